// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Contention Arbiter

This block is a synchronous, byte-wide true dual-port RAM with two symmetric ports, left and right. Each port has its own enable, write strobe, address, write data and registered read data. Either port can read or write any location in any cycle. The ports are fully independent until both target the same location.

When both ports are enabled on the same address, an arbiter drives an active-low busy flag to one of them. The port whose request arrived later gets the flag. A request arrives when the port's enable rises or its address changes. If both arrive in the same cycle, the right port gets the flag. A flagged port cannot write, but it can still read. A write held on a flagged port takes effect at the first clock edge after the flag clears.

A deselected port is in standby. It performs no access and reports its read data as not driven.

Top module: `dpr_contention_ram`

## Requirements
- R1: At a rising clock edge where a port has enable=1, write=1 and its busy_n=1, its write data is stored at its address.
- R2: At an edge where a port has enable=1 and write=0, the port's drive flag is 1 after that edge, and its read data holds the content the addressed location had just before that edge.
- R3: At an edge where a port has enable=0, that port changes no memory location, whatever its other inputs are. After that edge its drive flag is 0 and its read data is all zeros. An edge where a port writes also leaves drive=0 and read data zero after it.
- R4: busy_n of a port may be 0 only while both enables are 1 and the two addresses are equal. Whenever both enables are 1 and the addresses are equal, exactly one busy_n is 0.
- R5: The two busy_n outputs are never 0 at the same time. Both outputs are always driven, and both are 1 during and after reset until contention occurs.
- R6: A port's request is new in a cycle if its enable rose, or its address changed, relative to the previous cycle. When only one port's request is new and the addresses match, that port gets busy_n=0 and the other port keeps busy_n=1.
- R7: When both requests are new in the same cycle and the addresses match, the right port gets busy_n=0 and the left port keeps busy_n=1.
- R8: While the match holds and neither request is new, busy stays on the same port as in the previous cycle.
- R9: A write from a port with busy_n=0 leaves memory unchanged.
- R10: A write held on a port takes effect at the first edge where that port's busy_n is 1.
- R11: Reads are never blocked. Two ports reading the same location in the same cycle both receive the stored value, even though one of them is flagged busy.
- R12: A read at the same edge where the other port writes the same location returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| lft_en | input | 1 | Left port select, active high |
| lft_wr | input | 1 | Left port: 1 = write, 0 = read |
| lft_addr | input | ADDR_W | Left port address |
| lft_wdata | input | DATA_W | Left port write data |
| lft_rdata | output | DATA_W | Left port registered read data |
| lft_drive | output | 1 | Left read data valid (0 = standby / not driven) |
| lft_busy_n | output | 1 | Left contention flag, active low, always driven |
| rgt_en | input | 1 | Right port select, active high |
| rgt_wr | input | 1 | Right port: 1 = write, 0 = read |
| rgt_addr | input | ADDR_W | Right port address |
| rgt_wdata | input | DATA_W | Right port write data |
| rgt_rdata | output | DATA_W | Right port registered read data |
| rgt_drive | output | 1 | Right read data valid (0 = standby / not driven) |
| rgt_busy_n | output | 1 | Right contention flag, active low, always driven |

## Verification
A stale record of the previous address or enable marks the wrong request as new. That shows up on the busy_n outputs in the same cycle, because busy is combinational from the ports and that history. A wrong winner or a leaked write does not show on busy_n. It shows as corrupted content at the next read of that location, one cycle after the read is issued. The bench sweeps every address pair in both arrival orders, and it reads the whole array back at the end. Because of that, a wrong memory state is reported within one read pass of the write that caused it.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;
   typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;
   localparam int NUM_SIDES = 2;
   localparam int IDX_L = 0;
   localparam int IDX_R = 1;
endpackage

// File: rtl/dpr_port_if.sv
`timescale 1ns/1ps
// Per-port request tracking: detects a new request and gates the write.
module dpr_port_if #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic              busy,
   output logic              we,
   output logic              rd_req,
   output logic              fresh
);
   logic              prev_en;
   logic [ADDR_W-1:0] prev_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_en   <= 1'b0;
         prev_addr <= '0;
      end else begin
         prev_en   <= en;
         prev_addr <= addr;
      end
   end

   assign fresh  = en & (~prev_en | (addr != prev_addr));
   assign we     = en & wr & ~busy;
   assign rd_req = en & ~wr;

   // R6: a request that stays enabled on an unchanged address is not new
   p_stable_not_fresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && addr == $past(addr)) |-> !fresh);
endmodule

// File: rtl/dpr_arbiter.sv
`timescale 1ns/1ps
// Same-address contention arbiter: the later request gets busy.
module dpr_arbiter #(
   parameter int ADDR_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             en,
   input  logic [1:0][ADDR_W-1:0] addr,
   input  logic [1:0]             fresh,
   output logic [1:0]             busy
);
   import dpr_pkg::*;

   logic  match;
   side_e loser, loser_q;

   assign match = en[IDX_L] & en[IDX_R] & (addr[IDX_L] == addr[IDX_R]);

   always_comb begin
      unique case (fresh)
         2'b01:   loser = SIDE_L;   // only left is new
         2'b10:   loser = SIDE_R;   // only right is new
         2'b11:   loser = SIDE_R;   // same-cycle tie: left wins
         default: loser = loser_q;  // nothing new: keep owner
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     loser_q <= SIDE_R;
      else if (match) loser_q <= loser;
   end

   assign busy[IDX_L] = match & (loser == SIDE_L);
   assign busy[IDX_R] = match & (loser == SIDE_R);

   p_one_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(busy));
   p_tie_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (match && (&fresh)) |-> (busy[IDX_R] && !busy[IDX_L]));
   p_hold_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (match && $past(match) && fresh == 2'b00) |-> (busy == $past(busy)));
endmodule

// File: rtl/dpr_store.sv
`timescale 1ns/1ps
// Storage array with two write ports and two registered read ports.
module dpr_store #(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter bit IDLE_HOLD = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             we,
   input  logic [1:0]             rd_req,
   input  logic [1:0][ADDR_W-1:0] addr,
   input  logic [1:0][DATA_W-1:0] wdata,
   output logic [1:0][DATA_W-1:0] rdata,
   output logic [1:0]             drive
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we[0]) mem[addr[0]] <= wdata[0];
      if (we[1]) mem[addr[1]] <= wdata[1];
   end

   for (genvar p = 0; p < 2; p++) begin : g_rd
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) drive[p] <= 1'b0;
         else        drive[p] <= rd_req[p];
      end

      if (IDLE_HOLD) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         rdata[p] <= '0;
            else if (rd_req[p]) rdata[p] <= mem[addr[p]];
         end
      end else begin : g_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         rdata[p] <= '0;
            else if (rd_req[p]) rdata[p] <= mem[addr[p]];
            else                rdata[p] <= '0;
         end
         // R3: an idle cycle leaves the port quiet on the next cycle
         p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_req[p] |=> (!drive[p] && rdata[p] == '0));
      end

      // R2: a read request yields valid data one cycle later
      p_read_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
         rd_req[p] |=> drive[p]);
   end

   // R4/R9 upstream: the two write ports never collide on one location
   p_no_dual_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(we[0] && we[1] && addr[0] == addr[1]));
endmodule

// File: rtl/dpr_contention_ram.sv
`timescale 1ns/1ps
module dpr_contention_ram #(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter bit IDLE_HOLD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lft_en,
   input  logic              lft_wr,
   input  logic [ADDR_W-1:0] lft_addr,
   input  logic [DATA_W-1:0] lft_wdata,
   output logic [DATA_W-1:0] lft_rdata,
   output logic              lft_drive,
   output logic              lft_busy_n,
   input  logic              rgt_en,
   input  logic              rgt_wr,
   input  logic [ADDR_W-1:0] rgt_addr,
   input  logic [DATA_W-1:0] rgt_wdata,
   output logic [DATA_W-1:0] rgt_rdata,
   output logic              rgt_drive,
   output logic              rgt_busy_n
);
   import dpr_pkg::*;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr_w
      $error("dpr_contention_ram: ADDR_W must be 1..12");
   end
   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data_w
      $error("dpr_contention_ram: DATA_W must be 1..64");
   end

   logic [1:0]             en_v, wr_v, we_v, rd_v, fresh_v, busy_v, drive_v;
   logic [1:0][ADDR_W-1:0] addr_v;
   logic [1:0][DATA_W-1:0] wdata_v, rdata_v;

   assign en_v    = {rgt_en, lft_en};
   assign wr_v    = {rgt_wr, lft_wr};
   assign addr_v  = {rgt_addr, lft_addr};
   assign wdata_v = {rgt_wdata, lft_wdata};

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      dpr_port_if #(.ADDR_W(ADDR_W)) u_port (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (en_v[s]),
         .wr     (wr_v[s]),
         .addr   (addr_v[s]),
         .busy   (busy_v[s]),
         .we     (we_v[s]),
         .rd_req (rd_v[s]),
         .fresh  (fresh_v[s])
      );
   end

   dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_v),
      .addr  (addr_v),
      .fresh (fresh_v),
      .busy  (busy_v)
   );

   dpr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDLE_HOLD(IDLE_HOLD)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we_v),
      .rd_req (rd_v),
      .addr   (addr_v),
      .wdata  (wdata_v),
      .rdata  (rdata_v),
      .drive  (drive_v)
   );

   assign lft_rdata  = rdata_v[IDX_L];
   assign rgt_rdata  = rdata_v[IDX_R];
   assign lft_drive  = drive_v[IDX_L];
   assign rgt_drive  = drive_v[IDX_R];
   assign lft_busy_n = ~busy_v[IDX_L];
   assign rgt_busy_n = ~busy_v[IDX_R];

   p_busy_needs_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!lft_busy_n || !rgt_busy_n) |-> (lft_en && rgt_en && lft_addr == rgt_addr));
   p_match_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lft_en && rgt_en && lft_addr == rgt_addr) |-> (lft_busy_n != rgt_busy_n));
   p_blocked_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !lft_busy_n |-> !we_v[IDX_L]);
   p_blocked_right_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rgt_busy_n |-> !we_v[IDX_R]);
endmodule

// File: tb/test_dpr_contention_ram.sv
`timescale 1ns/1ps
module test_dpr_contention_ram;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lft_en = 0, lft_wr = 0, rgt_en = 0, rgt_wr = 0;
   logic [AW-1:0] lft_addr = '0, rgt_addr = '0;
   logic [DW-1:0] lft_wdata = '0, rgt_wdata = '0;
   logic [DW-1:0] lft_rdata, rgt_rdata;
   logic          lft_drive, rgt_drive, lft_busy_n, rgt_busy_n;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [DW-1:0] ref_mem [DEPTH];
   bit            pend = 0;
   string         pend_req;
   logic          exp_drv_l, exp_drv_r;
   logic [DW-1:0] exp_dat_l, exp_dat_r;

   always #4 clk = ~clk;   // 125 MHz

   dpr_contention_ram #(.ADDR_W(AW), .DATA_W(DW)) i_dpr_contention_ram (
      .clk(clk), .rst_n(rst_n),
      .lft_en(lft_en), .lft_wr(lft_wr), .lft_addr(lft_addr), .lft_wdata(lft_wdata),
      .lft_rdata(lft_rdata), .lft_drive(lft_drive), .lft_busy_n(lft_busy_n),
      .rgt_en(rgt_en), .rgt_wr(rgt_wr), .rgt_addr(rgt_addr), .rgt_wdata(rgt_wdata),
      .rgt_rdata(rgt_rdata), .rgt_drive(rgt_drive), .rgt_busy_n(rgt_busy_n)
   );

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] dat(int a, int b);
      return DW'((a * 29 + b * 7 + 3) & 255);
   endfunction

   // One cycle: check results of the previous cycle, apply inputs, check busy.
   task automatic step(logic le, logic lw, int la, logic [DW-1:0] ld,
                       logic re, logic rw, int ra, logic [DW-1:0] rd,
                       logic eb_l, logic eb_r, string req);
      @(negedge clk);
      if (pend) begin
         check(lft_drive == exp_drv_l, pend_req, "left drive", lft_drive, exp_drv_l);
         check(lft_rdata == exp_dat_l, pend_req, "left rdata", lft_rdata, exp_dat_l);
         check(rgt_drive == exp_drv_r, pend_req, "right drive", rgt_drive, exp_drv_r);
         check(rgt_rdata == exp_dat_r, pend_req, "right rdata", rgt_rdata, exp_dat_r);
      end
      lft_en = le; lft_wr = lw; lft_addr = AW'(la); lft_wdata = ld;
      rgt_en = re; rgt_wr = rw; rgt_addr = AW'(ra); rgt_wdata = rd;
      #1;
      check(lft_busy_n == !eb_l, req, "left busy_n", lft_busy_n, !eb_l);
      check(rgt_busy_n == !eb_r, req, "right busy_n", rgt_busy_n, !eb_r);
      exp_drv_l = le & !lw;
      exp_drv_r = re & !rw;
      exp_dat_l = exp_drv_l ? ref_mem[AW'(la)] : '0;
      exp_dat_r = exp_drv_r ? ref_mem[AW'(ra)] : '0;
      pend = 1; pend_req = req;
      if (le && lw && !eb_l) ref_mem[AW'(la)] = ld;
      if (re && rw && !eb_r) ref_mem[AW'(ra)] = rd;
   endtask

   task automatic idle(string req);
      step(0, 0, 0, '0, 0, 0, 0, '0, 0, 0, req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         check(0, "ALL", "watchdog expired", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state (R5, R3)
      check(lft_busy_n == 1 && rgt_busy_n == 1, "R5", "busy_n in reset", {lft_busy_n, rgt_busy_n}, 2'b11);
      check(lft_drive == 0 && rgt_drive == 0, "R3", "drive in reset", {lft_drive, rgt_drive}, 0);
      rst_n = 1;
      @(negedge clk);
      check(lft_rdata == 0 && rgt_rdata == 0, "R3", "rdata after reset", {lft_rdata, rgt_rdata}, 0);

      // R1: fill from the left, R2: read all from the right
      for (int a = 0; a < DEPTH; a++) step(1, 1, a, dat(a, 0), 0, 0, 0, '0, 0, 0, "R1");
      for (int a = 0; a < DEPTH; a++) step(0, 0, 0, '0, 1, 0, a, '0, 0, 0, "R2");
      // left reads while right writes mirrored addresses (never equal)
      for (int a = 0; a < DEPTH; a++)
         step(1, 0, a, '0, 1, 1, DEPTH - 1 - a, dat(a, 1), 0, 0, "R2");
      idle("R3");

      // R6/R8/R9/R10: sweep every address pair in both arrival orders
      for (int a = 0; a < DEPTH; a++) begin
         for (int b = 0; b < DEPTH; b++) begin
            step(1, 0, a, '0, 0, 0, 0, '0, 0, 0, "R2");
            step(1, 0, a, '0, 1, 1, b, dat(a, b + 2), 0, a == b, "R6");
            step(1, 0, a, '0, 1, 1, b, dat(a, b + 2), 0, a == b, "R8");
            step(0, 0, 0, '0, 1, 1, b, dat(a, b + 2), 0, 0, "R10");
            step(0, 0, 0, '0, 1, 0, b, '0, 0, 0, "R2");
            step(1, 1, a, dat(b, a + 5), 1, 0, b, '0, a == b, 0, "R9");
            idle("R3");
         end
      end

      // R7 tie, R12 read-during-write, R11 shared read, R3 standby
      for (int a = 0; a < DEPTH; a++) begin
         step(1, 1, a, dat(a, 40), 1, 1, a, dat(a, 41), 0, 1, "R7");
         step(0, 0, 0, '0, 1, 1, a, dat(a, 41), 0, 0, "R10");
         idle("R3");
         step(1, 1, a, dat(a, 42), 1, 0, a, '0, 0, 1, "R12");
         idle("R12");
         step(1, 0, a, '0, 1, 0, a, '0, 0, 1, "R11");
         step(0, 1, a, dat(a, 43), 0, 1, a, dat(a, 44), 0, 0, "R3");
      end

      // final readback through both ports (R1, R9, R3)
      for (int a = 0; a < DEPTH; a++) step(1, 0, a, '0, 1, 0, DEPTH - 1 - a, '0, 0, 0, "R9");
      idle("R1");
      idle("R3");

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule